// File: doc/BRIEF.md
# Flash Status Word with Sticky Failure Flags

This block keeps the 8-bit status word that a host polls while a flash write engine programs or erases the array. The word carries a ready flag that follows the engine's start and finish events, a flag for an erase held in suspension, and three failure flags. The engine sets the failure flags and only a clear-status command or reset removes them. Software can therefore run a long series of operations and check once at the end whether any of them failed.

The host reads the word through chip enable and output enable, both active low. The value is captured once, in the first clock cycle in which both strobes are sampled low. It then stays frozen until either strobe is released. A host that keeps the strobes low never sees a later change, so each poll must toggle a strobe. In word mode the upper data byte is driven as 00h. In byte mode only the lower byte lane is enabled.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the word is 80h (ready, no suspension, no failures), and both byte-lane enables and the data output are 0 while no read is in progress.
- R2: Bit 7 (ready) goes to 0 after an engine-start pulse and to 1 after an engine-done pulse. If both pulses arrive in the same cycle, start wins.
- R3: Bit 6 (suspended) goes to 1 after a suspend-enter pulse and to 0 after a suspend-exit pulse. If both pulses arrive in the same cycle, enter wins.
- R4: An erase-failure pulse sets bit 5, a program-failure pulse sets bit 4 and a supply-low pulse sets bit 3. Each pulse leaves every other bit unchanged. The bits stay set across later operations.
- R5: A clear-status pulse while not suspended clears bits 5, 4 and 3 and leaves bits 7 and 6 unchanged.
- R6: A clear-status pulse while bit 6 is 1 has no effect.
- R7: The value shown is the word as it stood in the cycle in which both strobes were first sampled low. Output appears one clock later and stays unchanged while both strobes remain low.
- R8: A later change to the word becomes visible only after chip enable or output enable is sampled high and then both are sampled low again.
- R9: During a read in word mode, the upper byte is 00h and the upper lane enable is 1. In byte mode the upper lane enable is 0.
- R10: Bits 2 to 0 of every value shown read 0.
- R11: A failure pulse in the same cycle as an accepted clear-status pulse leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_start | input | 1 | Write engine began an operation (pulse) |
| eng_done | input | 1 | Write engine finished (pulse) |
| susp_enter | input | 1 | Erase entered suspension (pulse) |
| susp_exit | input | 1 | Erase resumed (pulse) |
| fail_erase | input | 1 | Erase failure event (pulse) |
| fail_prog | input | 1 | Program failure event (pulse) |
| fail_supply | input | 1 | Supply-low failure event (pulse) |
| clr_cmd | input | 1 | Clear-status command (pulse) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| dq_o | output | 16 | Status data toward the host, 0 when not reading |
| dq_lo_en | output | 1 | Drive enable for the lower byte lane |
| dq_hi_en | output | 1 | Drive enable for the upper byte lane |

## Verification
The bench holds both strobes low while the engine finishes and a failure arrives. A design that tracked the live word would show the change in the middle of the read. It also presents failure and clear pulses in the same cycle, where a design with the wrong priority would lose the error. Clear is issued while an erase is suspended, where a faulty design would wipe the flags. Simultaneous start/done and enter/exit pulses are also driven, so a reversed priority would show the wrong ready or suspended bit. A long pseudo-random section then runs against a behavioural model, and the data and lane enables are compared on every cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W   = 8;
  localparam int ERR_W  = 3;
  localparam int POS_RDY  = 7;
  localparam int POS_SUSP = 6;
  localparam int POS_ERR0 = 3;   // err[0]=supply, err[1]=program, err[2]=erase
  localparam logic [SR_W-1:0] RESET_WORD = 8'h80;

  typedef struct packed {
    logic             ready;
    logic             susp;
    logic [ERR_W-1:0] err;
  } fsr_state_t;

  function automatic logic [SR_W-1:0] pack_word(input fsr_state_t s);
    logic [SR_W-1:0] w;
    w = '0;
    w[POS_RDY]  = s.ready;
    w[POS_SUSP] = s.susp;
    w[POS_ERR0 +: ERR_W] = s.err;
    return w;
  endfunction

  function automatic logic [ERR_W-1:0] next_err(input logic [ERR_W-1:0] cur,
                                                 input logic clr,
                                                 input logic [ERR_W-1:0] setv);
    return (clr ? '0 : cur) | setv;
  endfunction
endpackage

// File: rtl/fsr_flags.sv
module fsr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_start,
  input  logic eng_done,
  input  logic susp_enter,
  input  logic susp_exit,
  output logic ready_q,
  output logic susp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b0;
    end else begin
      if (eng_start)      ready_q <= 1'b0;
      else if (eng_done)  ready_q <= 1'b1;
      if (susp_enter)     susp_q  <= 1'b1;
      else if (susp_exit) susp_q  <= 1'b0;
    end
  end

  a_r2_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !ready_q);
  a_r2_done_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_start) |=> ready_q);
  a_r3_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    susp_enter |=> susp_q);
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky
  import fsr_pkg::*;
#(
  parameter int N = ERR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_cmd,
  input  logic         blocked,
  output logic [N-1:0] err_q,
  output logic         clr_apply
);
  assign clr_apply = clr_cmd && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= next_err(err_q, clr_apply, set_vec);
  end

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_apply |=> ((err_q & $past(err_q)) == $past(err_q)));
  a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && set_vec == '0) |=> (err_q == $past(err_q)));
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fsr_snapshot.sv
module fsr_snapshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  output logic         frame_q,
  output logic [W-1:0] snap_q,
  output logic         capture
);
  logic read_active;
  assign read_active = !ce_n && !oe_n;
  assign capture     = read_active && !frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      frame_q <= read_active;
      if (capture) snap_q <= live;
    end
  end

  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_q && read_active) |=> $stable(snap_q));
  a_r8_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_start,
  input  logic              eng_done,
  input  logic              susp_enter,
  input  logic              susp_exit,
  input  logic              fail_erase,
  input  logic              fail_prog,
  input  logic              fail_supply,
  input  logic              clr_cmd,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_lo_en,
  output logic              dq_hi_en
);
  localparam int HI_W = DATA_W - SR_W;

  logic             ready_q, susp_q, clr_apply, frame_q, capture;
  logic [ERR_W-1:0] err_q, fail_vec;
  logic [SR_W-1:0]  live_word, snap_q;
  fsr_state_t       st;

  assign fail_vec = {fail_erase, fail_prog, fail_supply};

  fsr_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .eng_start(eng_start), .eng_done(eng_done),
    .susp_enter(susp_enter), .susp_exit(susp_exit),
    .ready_q(ready_q), .susp_q(susp_q)
  );

  fsr_sticky #(.N(ERR_W)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_vec(fail_vec), .clr_cmd(clr_cmd), .blocked(susp_q),
    .err_q(err_q), .clr_apply(clr_apply)
  );

  always_comb begin
    st.ready  = ready_q;
    st.susp   = susp_q;
    st.err    = err_q;
    live_word = pack_word(st);
  end

  fsr_snapshot #(.W(SR_W)) u_snap (
    .clk(clk), .rst_n(rst_n),
    .ce_n(ce_n), .oe_n(oe_n),
    .live(live_word),
    .frame_q(frame_q), .snap_q(snap_q), .capture(capture)
  );

  assign dq_lo_en = frame_q;
  assign dq_o[SR_W-1:0] = frame_q ? snap_q : '0;

  generate
    if (HI_W > 0) begin : g_upper
      assign dq_o[DATA_W-1:SR_W] = '0;
      assign dq_hi_en = frame_q && word_mode;
    end else begin : g_narrow
      assign dq_hi_en = 1'b0;
    end
  endgenerate

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hi_en |-> (dq_o[DATA_W-1:SR_W] == '0));
  a_r10_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (dq_o[2:0] == 3'b000));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_lo_en |-> (dq_o == '0 && !dq_hi_en));
  a_r5_clear_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_apply && !eng_start && !eng_done && !susp_enter && !susp_exit)
      |=> (ready_q == $past(ready_q) && susp_q == $past(susp_q)));
endmodule

// File: tb/flash_status_reg_test.sv
module flash_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = '0;  // {clr, start, done, enter, exit, ferase, fprog, fsupply}
  logic ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1;
  logic [15:0] dq_o;
  logic dq_lo_en, dq_hi_en;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  flash_status_reg uut (
    .clk(clk), .rst_n(rst_n),
    .eng_start(ev[6]), .eng_done(ev[5]),
    .susp_enter(ev[4]), .susp_exit(ev[3]),
    .fail_erase(ev[2]), .fail_prog(ev[1]), .fail_supply(ev[0]),
    .clr_cmd(ev[7]),
    .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
    .dq_o(dq_o), .dq_lo_en(dq_lo_en), .dq_hi_en(dq_hi_en)
  );

  // behavioural reference model
  int m_rdy = 1, m_susp = 0, m_errs = 0, m_in_read = 0, m_seen = 0;
  always @(posedge clk) begin
    int now_word;
    if (!rst_n) begin
      m_rdy = 1; m_susp = 0; m_errs = 0; m_in_read = 0; m_seen = 0;
    end else begin
      now_word = m_rdy * 128 + m_susp * 64 + m_errs * 8;
      if (!ce_n && !oe_n) begin
        if (m_in_read == 0) m_seen = now_word;
        m_in_read = 1;
      end else m_in_read = 0;
      if (ev[7] && m_susp == 0) m_errs = 0;
      m_errs = m_errs | (ev[2] ? 4 : 0) | (ev[1] ? 2 : 0) | (ev[0] ? 1 : 0);
      if (ev[6]) m_rdy = 0; else if (ev[5]) m_rdy = 1;
      if (ev[4]) m_susp = 1; else if (ev[3]) m_susp = 0;
    end
  end

  always @(negedge clk) begin
    int e_dq, e_lo, e_hi;
    e_lo = m_in_read;
    e_hi = m_in_read & int'(word_mode);
    e_dq = m_in_read ? m_seen : 0;
    n_cmp++;
    if (int'(dq_o) != e_dq || int'(dq_lo_en) != e_lo || int'(dq_hi_en) != e_hi) begin
      n_bad++;
      $display("FAIL %s model: dq=%h lo=%0d hi=%0d expected dq=%h lo=%0d hi=%0d",
               tag, dq_o, dq_lo_en, dq_hi_en, e_dq[15:0], e_lo, e_hi);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic fire(input logic [7:0] m);
    ev = m; step(); ev = '0;
  endtask

  task automatic check(input string t, input logic [15:0] exp_dq, input logic exp_hi);
    n_cmp++;
    if (dq_o !== exp_dq || dq_lo_en !== 1'b1 || dq_hi_en !== exp_hi || dq_o[2:0] !== 3'b000) begin
      n_bad++;
      $display("FAIL %s: dq=%h lo=%b hi=%b expected dq=%h lo=1 hi=%b",
               t, dq_o, dq_lo_en, dq_hi_en, exp_dq, exp_hi);
    end
  endtask

  task automatic rd(input string t, input logic [15:0] exp_dq);
    tag = t;
    ce_n = 1'b0; oe_n = 1'b0; step();
    check(t, exp_dq, word_mode);
    ce_n = 1'b1; oe_n = 1'b1; step();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1 idle and reset value
    n_cmp++;
    if (dq_o !== 16'h0 || dq_lo_en !== 1'b0 || dq_hi_en !== 1'b0) begin
      n_bad++; $display("FAIL R1 idle: dq=%h lo=%b hi=%b expected 0 0 0", dq_o, dq_lo_en, dq_hi_en);
    end
    rd("R1", 16'h0080);
    // R2 start clears ready
    tag = "R2"; fire(8'h40);
    rd("R2", 16'h0000);
    // R7 hold during read while done + program failure arrive
    tag = "R7"; ce_n = 1'b0; oe_n = 1'b0; step();
    check("R7", 16'h0000, 1'b1);
    fire(8'h22);
    step();
    check("R7", 16'h0000, 1'b1);
    // R8 oe toggle reveals new value
    tag = "R8"; oe_n = 1'b1; step(); oe_n = 1'b0; step();
    check("R8", 16'h0090, 1'b1);
    ce_n = 1'b1; oe_n = 1'b1; step();
    // R4 erase failure keeps program failure
    tag = "R4"; fire(8'h04);
    rd("R4", 16'h00B0);
    // R3 / R6 clear blocked while suspended
    tag = "R3"; fire(8'h10);
    rd("R3", 16'h00F0);
    tag = "R6"; fire(8'h80);
    rd("R6", 16'h00F0);
    // R5 clear after resume
    tag = "R3"; fire(8'h08);
    rd("R3", 16'h00B0);
    tag = "R5"; fire(8'h80);
    rd("R5", 16'h0080);
    // R11 set beats clear
    tag = "R11"; fire(8'h81);
    rd("R11", 16'h0088);
    fire(8'h80);
    // R9 byte mode
    word_mode = 1'b0; rd("R9", 16'h0080);
    word_mode = 1'b1; rd("R9", 16'h0080);
    // R2 start wins over done; R3 enter wins over exit
    tag = "R2"; fire(8'h60);
    rd("R2", 16'h0000);
    fire(8'h20);
    tag = "R3"; fire(8'h18);
    rd("R3", 16'h00C0);
    fire(8'h08);
    rd("R10", 16'h0080);
    // pseudo-random run against the model
    tag = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev = (lfsr[3:0] == 4'h0) ? lfsr[15:8] : 8'h00;
      ce_n = lfsr[4] & lfsr[5];
      oe_n = lfsr[6] & lfsr[7] & lfsr[9];
      word_mode = lfsr[11] | lfsr[2];
      if (i == 1500) tag = "R8";
      step();
    end
    ev = '0; ce_n = 1'b1; oe_n = 1'b1; step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule